// File: doc/BRIEF.md
# Streaming windowed pooling reducer

This block folds a pre-ordered stream of single-precision values into pooled results. Upstream logic delivers the elements of each pooling window back to back, so the block never stores a window. A vector of lanes (channels) is processed in parallel, one beat per cycle. After every `period` accepted beats the block emits one beat that holds, per lane, either the largest element of the window or the window sum multiplied by a reciprocal scale. It repeats this for `num` windows and then pulses `done`.

A command is loaded by a one-cycle `start` strobe while the block is idle. The strobe carries the function code, the window length, the window count, the number of active lanes and a 32-bit float scale. A command that breaks the legality rules raises a sticky `cfg_err` and produces no traffic. Both the input and the output use valid/ready handshakes. While a result waits for the consumer, the input is held off.

Top module: `pool_stream_reducer`

## Requirements
- R1: The function code is 8 bits: 1 selects max and 2 selects average. Any other code on `start` sets `cfg_err` in the next cycle, leaves `busy` low, and keeps `in_ready` and `out_valid` low.
- R2: In max mode the scale must be exactly 0x3F800000 (1.0), and any other value is a configuration error. In average mode any scale is accepted.
- R3: A period of zero, a num of zero, or an active lane count of zero or above NUM_LANES is a configuration error.
- R4: Each output beat is built from exactly `period` consecutive accepted input beats, and a command yields exactly `num` output beats. `done` is high for one cycle, with `busy` low, in the cycle after the final output handshake.
- R5: Max mode starts each window at -infinity and outputs the largest element without scaling. When +0.0 and -0.0 compare equal, the value seen first is kept.
- R6: Average mode starts each window at +0.0, sums the elements, and multiplies the sum once by the scale.
- R7: Arithmetic is IEEE single precision with round-to-nearest-even. Subnormal inputs and results become zero of the same sign, overflow gives infinity, and any NaN result is 0x7FC00000.
- R8: Lanes at or above the active lane count output 0x00000000, and their input data is ignored. Lane k occupies bits [32k+31:32k] of both data buses.
- R9: `out_valid` rises in the cycle after the last element of a window is accepted. `in_ready` is high only while busy and no output beat is pending.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` stays stable.
- R11: `cfg_err` stays set until the next `start`. A legal `start` clears it.
- R12: After reset `busy`, `cfg_err`, `done`, `in_ready` and `out_valid` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads a command while idle |
| cfg_func | input | 8 | Function code (1 max, 2 average) |
| cfg_period | input | 16 | Elements per window |
| cfg_num | input | 16 | Windows per command |
| cfg_lanes | input | 8 | Active lane count |
| cfg_scale | input | 32 | Float scale (1/N for average) |
| busy | output | 1 | A command is running |
| cfg_err | output | 1 | Sticky configuration error |
| done | output | 1 | One-cycle pulse when a command ends |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 32*NUM_LANES | One float per lane |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32*NUM_LANES | One pooled float per lane |

## Verification
The assertions assume that `start` is pulsed only while the block is idle. They also assume that the configuration inputs matter only in the cycle of that strobe. The bench raises `start` for a single cycle after the previous command has reported `done` or an error, so the first assumption holds. The stall assertion takes for granted that the consumer may withhold `out_ready` for any length of time. The bench holds it off for several cycles while the producer still offers data, and it changes its inputs only at falling clock edges.

// File: rtl/pool_pkg.sv
package pool_pkg;

  typedef enum logic [7:0] {
    FN_NONE = 8'd0,
    FN_MAX  = 8'd1,
    FN_AVG  = 8'd2
  } pool_fn_e;

  localparam logic [31:0] F_QNAN    = 32'h7FC0_0000;
  localparam logic [31:0] F_ONE     = 32'h3F80_0000;
  localparam logic [31:0] F_NEG_INF = 32'hFF80_0000;

  function automatic logic f_is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic logic f_is_inf(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] == 23'd0);
  endfunction

  // Orders floats as unsigned keys; negative values invert.
  function automatic logic [31:0] f_key(input logic [31:0] v);
    return v[31] ? ~v : {1'b1, v[30:0]};
  endfunction

  // Running max; subnormal x flushed, zero ties keep the accumulator.
  function automatic logic [31:0] f_max(input logic [31:0] acc, input logic [31:0] x);
    logic [31:0] xf;
    xf = (x[30:23] == 8'd0) ? {x[31], 31'd0} : x;
    if (f_is_nan(acc) || f_is_nan(xf)) return F_QNAN;
    if (acc[30:0] == 31'd0 && xf[30:0] == 31'd0) return acc;
    return (f_key(xf) > f_key(acc)) ? xf : acc;
  endfunction

  // Single-precision add, RNE, flush-to-zero.
  function automatic logic [31:0] f_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] big, sml;
    logic [26:0] mb, ms;
    logic [53:0] t;
    logic [27:0] s;
    logic [24:0] m;
    logic        sr, rnd;
    int          e, d;
    if (f_is_nan(a) || f_is_nan(b)) return F_QNAN;
    if (f_is_inf(a) && f_is_inf(b)) return (a[31] == b[31]) ? a : F_QNAN;
    if (f_is_inf(a)) return a;
    if (f_is_inf(b)) return b;
    if (a[30:23] == 8'd0 && b[30:23] == 8'd0) return {a[31] & b[31], 31'd0};
    if (a[30:23] == 8'd0) return b;
    if (b[30:23] == 8'd0) return a;
    if (a[30:0] >= b[30:0]) begin big = a; sml = b; end
    else begin big = b; sml = a; end
    sr = big[31];
    e  = int'(big[30:23]);
    d  = int'(big[30:23]) - int'(sml[30:23]);
    mb = {1'b1, big[22:0], 3'b000};
    if (d > 53) ms = 27'd1;
    else begin
      t  = {1'b1, sml[22:0], 3'b000, 27'd0} >> d;
      ms = t[53:27] | {26'd0, |t[26:0]};
    end
    if (a[31] == b[31]) s = {1'b0, mb} + {1'b0, ms};
    else                s = {1'b0, mb} - {1'b0, ms};
    if (s == 28'd0) return 32'd0;
    if (s[27]) begin
      s = {1'b0, s[27:2], s[1] | s[0]};
      e = e + 1;
    end else begin
      for (int i = 0; i < 26; i++)
        if (!s[26]) begin s = {s[26:0], 1'b0}; e = e - 1; end
    end
    if (e <= 0) return {sr, 31'd0};
    rnd = s[2] & (s[1] | s[0] | s[3]);
    m   = {1'b0, s[26:3]} + 25'(rnd);
    if (m[24]) begin m = m >> 1; e = e + 1; end
    if (e >= 255) return {sr, 8'hFF, 23'd0};
    return {sr, 8'(e), m[22:0]};
  endfunction

  // Single-precision multiply, RNE, flush-to-zero.
  function automatic logic [31:0] f_mul(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    logic [23:0] mt;
    logic [24:0] m;
    logic        sr, g, st, za, zb;
    int          e;
    sr = a[31] ^ b[31];
    za = (a[30:23] == 8'd0);
    zb = (b[30:23] == 8'd0);
    if (f_is_nan(a) || f_is_nan(b)) return F_QNAN;
    if (f_is_inf(a) || f_is_inf(b)) return (za || zb) ? F_QNAN : {sr, 8'hFF, 23'd0};
    if (za || zb) return {sr, 31'd0};
    p = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin
      mt = p[47:24]; g = p[23]; st = |p[22:0]; e = e + 1;
    end else begin
      mt = p[46:23]; g = p[22]; st = |p[21:0];
    end
    m = {1'b0, mt} + 25'(g & (st | mt[0]));
    if (m[24]) begin m = m >> 1; e = e + 1; end
    if (e >= 255) return {sr, 8'hFF, 23'd0};
    if (e <= 0) return {sr, 31'd0};
    return {sr, 8'(e), m[22:0]};
  endfunction

endpackage

// File: rtl/pool_cfg_check.sv
module pool_cfg_check
  import pool_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16
) (
  input  logic [7:0]       func_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] num_i,
  input  logic [7:0]       lanes_i,
  input  logic [31:0]      scale_i,
  output logic             legal_o
);
  logic fn_ok, len_ok, lane_ok;

  // R1, R2: max needs unit scale, average takes any scale
  assign fn_ok   = (func_i == FN_MAX && scale_i == F_ONE) || (func_i == FN_AVG);
  // R3
  assign len_ok  = (period_i != '0) && (num_i != '0);
  assign lane_ok = (lanes_i != 8'd0) && (32'(lanes_i) <= NUM_LANES);
  assign legal_o = fn_ok && len_ok && lane_ok;
endmodule

// File: rtl/pool_lane.sv
module pool_lane
  import pool_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        clear_avg_i,
  input  logic        accept_i,
  input  logic        last_i,
  input  logic        is_avg_i,
  input  logic        active_i,
  input  logic [31:0] scale_i,
  input  logic [31:0] x_i,
  output logic [31:0] res_o
);
  logic [31:0] acc_q, fold, finish, ident;

  assign ident  = is_avg_i ? 32'd0 : F_NEG_INF;
  assign fold   = is_avg_i ? f_add(acc_q, x_i) : f_max(acc_q, x_i);
  assign finish = is_avg_i ? f_mul(fold, scale_i) : fold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 32'd0;
      res_o <= 32'd0;
    end else if (clear_i) begin
      acc_q <= clear_avg_i ? 32'd0 : F_NEG_INF;
      res_o <= 32'd0;
    end else if (accept_i && active_i) begin
      if (last_i) begin
        res_o <= finish;
        acc_q <= ident;
      end else begin
        acc_q <= fold;
      end
    end
  end

  assert_idle_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> res_o == 32'd0);
endmodule

// File: rtl/pool_stream_reducer.sv
module pool_stream_reducer
  import pool_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              cfg_func,
  input  logic [CNT_W-1:0]        cfg_period,
  input  logic [CNT_W-1:0]        cfg_num,
  input  logic [7:0]              cfg_lanes,
  input  logic [31:0]             cfg_scale,
  output logic                    busy,
  output logic                    cfg_err,
  output logic                    done,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [32*NUM_LANES-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [32*NUM_LANES-1:0] out_data
);
  localparam int DW = 32 * NUM_LANES;

  logic             busy_q, err_q, done_q, ov_q, avg_q;
  logic [CNT_W-1:0] period_q, num_q, elem_cnt, win_cnt;
  logic [7:0]       lanes_q;
  logic [31:0]      scale_q;
  logic             cfg_legal, start_take, accept, last_elem, out_fire, last_win;
  logic [NUM_LANES-1:0] lane_act;

  pool_cfg_check #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_cfg (
    .func_i(cfg_func), .period_i(cfg_period), .num_i(cfg_num),
    .lanes_i(cfg_lanes), .scale_i(cfg_scale), .legal_o(cfg_legal)
  );

  assign start_take = start && !busy_q;
  assign in_ready   = busy_q && !ov_q;
  assign accept     = in_valid && in_ready;
  assign last_elem  = accept && (elem_cnt == period_q - 1'b1);
  assign out_fire   = ov_q && out_ready;
  assign last_win   = out_fire && (win_cnt == num_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0; ov_q <= 1'b0; avg_q <= 1'b0;
      period_q <= '0; num_q <= '0; elem_cnt <= '0; win_cnt <= '0;
      lanes_q <= 8'd0; scale_q <= 32'd0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        err_q <= !cfg_legal;
        if (cfg_legal) begin
          busy_q   <= 1'b1;
          avg_q    <= (cfg_func == FN_AVG);
          period_q <= cfg_period;
          num_q    <= cfg_num;
          lanes_q  <= cfg_lanes;
          scale_q  <= cfg_scale;
          elem_cnt <= '0;
          win_cnt  <= '0;
        end
      end else if (busy_q) begin
        if (accept) begin
          elem_cnt <= last_elem ? '0 : elem_cnt + 1'b1;
          if (last_elem) ov_q <= 1'b1;
        end
        if (out_fire) begin
          ov_q    <= 1'b0;
          win_cnt <= win_cnt + 1'b1;
          if (last_win) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_act[g] = (32'(g) < 32'(lanes_q));
    pool_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .clear_i(start_take && cfg_legal),
      .clear_avg_i(cfg_func == FN_AVG),
      .accept_i(accept), .last_i(last_elem), .is_avg_i(avg_q),
      .active_i(lane_act[g]), .scale_i(scale_q),
      .x_i(in_data[g*32 +: 32]), .res_o(out_data[g*32 +: 32])
    );
  end

  assign busy      = busy_q;
  assign cfg_err   = err_q;
  assign done      = done_q;
  assign out_valid = ov_q;

  assert_bad_cfg_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !cfg_legal |=> cfg_err && !busy);
  assert_no_beats_on_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid && !in_ready);
  assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_done_after_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready) && !busy);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !start |=> cfg_err);

  logic unused_dw;
  assign unused_dw = (DW == 0);
endmodule

// File: tb/test_pool_stream_reducer.sv
module test_pool_stream_reducer;
  localparam int L  = 4;
  localparam int DW = 32 * L;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]    cfg_func = 8'd0, cfg_lanes = 8'd0;
  logic [15:0]   cfg_period = 16'd0, cfg_num = 16'd0;
  logic [31:0]   cfg_scale = 32'd0;
  logic          busy, cfg_err, done, in_ready, out_valid;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0, out_data;
  int            n_cmp = 0, n_bad = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  pool_stream_reducer #(.NUM_LANES(L), .CNT_W(16)) i_pool_stream_reducer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_func(cfg_func),
    .cfg_period(cfg_period), .cfg_num(cfg_num), .cfg_lanes(cfg_lanes),
    .cfg_scale(cfg_scale), .busy(busy), .cfg_err(cfg_err), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic [7:0]    func;
    logic [31:0]   scale;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
    logic [DW-1:0] expv;
  } vec_t;

  // Lanes written {lane3, lane2, lane1, lane0}; period 2, num 1, 4 lanes.
  localparam vec_t VECS [8] = '{
    // R5 ordinary max
    '{8'd1, 32'h3F800000, {32'h3F000000, 32'h40400000, 32'hC0000000, 32'h3F800000},
      {32'h3E800000, 32'hC0800000, 32'hBF800000, 32'h40000000},
      {32'h3F000000, 32'h40400000, 32'hBF800000, 32'h40000000}},
    // R5 signed zero ties, all -inf window, +inf
    '{8'd1, 32'h3F800000, {32'h7F800000, 32'hFF800000, 32'h80000000, 32'h00000000},
      {32'h3F800000, 32'hFF800000, 32'h00000000, 32'h80000000},
      {32'h7F800000, 32'hFF800000, 32'h80000000, 32'h00000000}},
    // R7 NaN and subnormal inputs in max
    '{8'd1, 32'h3F800000, {32'h40A00000, 32'hBF800000, 32'h00000001, 32'h7FA00000},
      {32'h40A00000, 32'h80000005, 32'hBF800000, 32'h3F800000},
      {32'h40A00000, 32'h80000000, 32'h00000000, 32'h7FC00000}},
    // R6 average, scale 0.5
    '{8'd2, 32'h3F000000, {32'h40200000, 32'hC0000000, 32'h40400000, 32'h3F800000},
      {32'h3FC00000, 32'h3F800000, 32'h40A00000, 32'h40000000},
      {32'h40000000, 32'hBF000000, 32'h40800000, 32'h3FC00000}},
    // R6/R7 infinities, cancellation, +0 start with -0 inputs
    '{8'd2, 32'h3F000000, {32'h80000000, 32'h3F800000, 32'h7F800000, 32'h7F800000},
      {32'h80000000, 32'hBF800000, 32'hFF800000, 32'h3F800000},
      {32'h00000000, 32'h00000000, 32'h7FC00000, 32'h7F800000}},
    // R7 ties to even, overflow, subnormal sum
    '{8'd2, 32'h3F800000, {32'h00800000, 32'h7F7FFFFF, 32'h3F800001, 32'h3F800000},
      {32'h80800001, 32'h7F7FFFFF, 32'h33800000, 32'h33800000},
      {32'h80000000, 32'h7F800000, 32'h3F800002, 32'h3F800000}},
    // R6 scale 0.25, subnormal input
    '{8'd2, 32'h3E800000, {32'h3F800000, 32'h41000000, 32'h00000003, 32'h40800000},
      {32'h3F800000, 32'hC1000000, 32'h3F800000, 32'h40800000},
      {32'h3F000000, 32'h00000000, 32'h3E800000, 32'h40000000}},
    // R7 subnormal product flushed
    '{8'd2, 32'h00800000, {32'h3F800000, 32'h40000000, 32'hBE800000, 32'h3E800000},
      {32'h3F800000, 32'h40000000, 32'hBE800000, 32'h3E800000},
      {32'h01000000, 32'h01800000, 32'h80000000, 32'h00000000}}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic cmd(input logic [7:0] f, input logic [15:0] p, input logic [15:0] n,
                     input logic [7:0] ln, input logic [31:0] sc);
    @(negedge clk);
    start = 1'b1; cfg_func = f; cfg_period = p; cfg_num = n; cfg_lanes = ln; cfg_scale = sc;
    @(negedge clk);
    start = 1'b0; cfg_func = 8'hAA; cfg_period = 16'h0; cfg_num = 16'h0; cfg_scale = 32'h0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = {L{32'hDEADBEEF}};
  endtask

  task automatic pop(output logic [DW-1:0] d);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    d = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic bad_cfg(input string req, input logic [7:0] f, input logic [15:0] p,
                         input logic [15:0] n, input logic [7:0] ln, input logic [31:0] sc);
    cmd(f, p, n, ln, sc);
    chk(req, "cfg_err set", 32'(cfg_err), 32'd1);
    chk(req, "busy low", 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk(req, "no in_ready", 32'(in_ready), 32'd0);
    chk(req, "no out_valid", 32'(out_valid), 32'd0);
    chk("R11", "cfg_err sticky", 32'(cfg_err), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] got, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy", 32'(busy), 32'd0);
    chk("R12", "cfg_err", 32'(cfg_err), 32'd0);
    chk("R12", "done", 32'(done), 32'd0);
    chk("R12", "in_ready", 32'(in_ready), 32'd0);
    chk("R12", "out_valid", 32'(out_valid), 32'd0);
    chk("R12", "out_data lane0", out_data[31:0], 32'd0);

    // Table walk: R5 R6 R7 R9 R4
    foreach (VECS[i]) begin
      cmd(VECS[i].func, 16'd2, 16'd1, 8'd4, VECS[i].scale);
      chk("R4", "busy after start", 32'(busy), 32'd1);
      push(VECS[i].e0);
      chk("R9", "no result mid-window", 32'(out_valid), 32'd0);
      push(VECS[i].e1);
      chk("R9", "out_valid after last", 32'(out_valid), 32'd1);
      chk("R9", "in_ready blocked", 32'(in_ready), 32'd0);
      pop(got);
      for (int k = 0; k < L; k++)
        chk(VECS[i].func == 8'd1 ? "R5/R7" : "R6/R7", $sformatf("vec %0d lane %0d", i, k),
            got[k*32 +: 32], VECS[i].expv[k*32 +: 32]);
      chk("R4", "done pulse", 32'(done), 32'd1);
      chk("R4", "idle at done", 32'(busy), 32'd0);
    end

    // R10 R8 R4: max, period 3, num 2, two active lanes, stalled consumer
    cmd(8'd1, 16'd3, 16'd2, 8'd2, 32'h3F800000);
    fork
      begin
        push({32'h40A00000, 32'h40A00000, 32'hBF800000, 32'h3F800000});
        push({32'h40A00000, 32'h40A00000, 32'hC0400000, 32'h40800000});
        push({32'h40A00000, 32'h40A00000, 32'hC0000000, 32'h40000000});
        push({32'h40A00000, 32'h40A00000, 32'h3F000000, 32'h40E00000});
        push({32'h40A00000, 32'h40A00000, 32'h40400000, 32'h40C00000});
        push({32'h40A00000, 32'h40A00000, 32'h40200000, 32'h41000000});
      end
      begin
        while (!out_valid) @(negedge clk);
        held = out_data;
        for (int c = 0; c < 3; c++) begin
          @(negedge clk);
          chk("R10", "data held", out_data[63:0], held[63:0]);
          chk("R9", "ready low while stalled", 32'(in_ready), 32'd0);
        end
        pop(got);
        chk("R5", "w0 lane0", got[31:0], 32'h40800000);
        chk("R5", "w0 lane1", got[63:32], 32'hBF800000);
        chk("R8", "w0 lane2", got[95:64], 32'd0);
        chk("R8", "w0 lane3", got[127:96], 32'd0);
        chk("R4", "no done mid-command", 32'(done), 32'd0);
        pop(got);
        chk("R5", "w1 lane0", got[31:0], 32'h41000000);
        chk("R5", "w1 lane1", got[63:32], 32'h40400000);
        chk("R8", "w1 lane3", got[127:96], 32'd0);
      end
    join
    chk("R4", "done after second", 32'(done), 32'd1);

    // R4 R6 R8: period 1, num 3, one lane, scale 2.0
    cmd(8'd2, 16'd1, 16'd3, 8'd1, 32'h40000000);
    for (int w = 0; w < 3; w++) begin
      push({32'h41200000, 32'h41200000, 32'h41200000, 32'h3F800000 + (w == 0 ? 32'h0 : (w == 1 ? 32'h00800000 : 32'h00C00000))});
      pop(got);
      chk("R6", $sformatf("window %0d lane0", w), got[31:0],
          (w == 0) ? 32'h40000000 : ((w == 1) ? 32'h40800000 : 32'h40C00000));
      chk("R8", $sformatf("window %0d lane1", w), got[63:32], 32'd0);
      chk("R4", $sformatf("done at window %0d", w), 32'(done), (w == 2) ? 32'd1 : 32'd0);
    end

    // Configuration errors
    bad_cfg("R1", 8'd0, 16'd2, 16'd1, 8'd4, 32'h3F800000);
    bad_cfg("R1", 8'd3, 16'd2, 16'd1, 8'd4, 32'h3F800000);
    bad_cfg("R2", 8'd1, 16'd2, 16'd1, 8'd4, 32'h3F000000);
    bad_cfg("R3", 8'd2, 16'd0, 16'd1, 8'd4, 32'h3F000000);
    bad_cfg("R3", 8'd2, 16'd2, 16'd0, 8'd4, 32'h3F000000);
    bad_cfg("R3", 8'd2, 16'd2, 16'd1, 8'd0, 32'h3F000000);
    bad_cfg("R3", 8'd2, 16'd2, 16'd1, 8'd5, 32'h3F000000);

    // R11 legal start clears the flag
    cmd(8'd1, 16'd1, 16'd1, 8'd1, 32'h3F800000);
    chk("R11", "cleared by legal start", 32'(cfg_err), 32'd0);
    chk("R11", "running", 32'(busy), 32'd1);
    push({32'h0, 32'h0, 32'h0, 32'hC0A00000});
    pop(got);
    chk("R5", "single element window", got[31:0], 32'hC0A00000);

    summary();
  end
endmodule